// File: doc/BRIEF.md
# Dual 8-bit / Cascaded 16-bit PWM Generator

This block drives two pulse-width-modulated pins. In its default arrangement it runs two independent 8-bit channels, each with its own period, duty and enable. Setting the wide-mode input joins the two channels into one 16-bit channel. Channel 0's counter becomes the low byte, its carry advances channel 1's counter, and the waveform appears on pin 0.

Both channels count pulses of one shared count clock. That clock is chosen between a time-base tick and the overflow pulse of an external 8-bit auto-reload timer. Each period and duty value is written to a shadow input and only takes effect at a period boundary. This lets software retune a channel without producing a runt pulse.

In 16-bit mode a dithered option is available for driving a simple RC filter as a DAC. The full 65536-count cycle is cut into 256 sub-periods of 256 counts each. Every sub-period carries a base pulse set by the duty high byte. The duty low byte then places one extra count in that many sub-periods, spread evenly by a bit-reversed sub-period index. The total high time is still the 16-bit duty, but the ripple frequency is 256 times higher.

Top module: `pwm_dual_wide`

## Requirements
- R1: In 8-bit mode each enabled channel counts selected ticks from 0 up to its active period P and then returns to 0, giving P+1 counts per period. Its pin is high while the count is below the active duty D.
- R2: The count clock is `tb_tick_i` when `src_sel_i` is 0 and `tmr_ovf_i` when `src_sel_i` is 1. Pulses on the unselected input have no effect on the counters or the pins.
- R3: Period and duty inputs are copied into the active values only in two cases: on the tick that returns the count to 0, or on every cycle while the channel is disabled. A change at any other time does not alter the pin until the next period starts.
- R4: An active duty of 0 holds the pin low. An active duty greater than or equal to the active period holds the pin high for the whole period.
- R5: A channel whose enable is low drives its pin low in the same cycle and holds its counter at 0. After re-enabling, the counter starts again from 0.
- R6: With `wide_i` high, the 16-bit count {channel 1, channel 0} runs against period {per1_i, per0_i} and duty {duty1_i, duty0_i} under the R1/R3/R4 rules. `en0_i` alone enables it, the result appears on `pwm0_o`, `pwm1_o` is held low, and `en1_i` has no effect.
- R7: With `wide_i` and `hs_i` high, the period is fixed at 65536 counts and the period inputs are ignored. Let s be the count high byte, p the low byte, h the duty high byte and l the duty low byte. The pin is high when p < h + e, where e is 1 if the bit-reversed s is below l and 0 otherwise. Over one full period the pin is therefore high for exactly the 16-bit duty count.
- R8: While `rst_ni` is low, both pins are low and all counters and active values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tb_tick_i | input | 1 | Time-base count pulse, one cycle wide |
| tmr_ovf_i | input | 1 | Auto-reload timer overflow pulse, one cycle wide |
| src_sel_i | input | 1 | Count-clock select: 0 time base, 1 timer overflow |
| wide_i | input | 1 | 1 joins both channels into one 16-bit channel |
| hs_i | input | 1 | 1 selects the dithered mode while wide_i is 1 |
| en0_i | input | 1 | Channel 0 enable (also the 16-bit channel enable) |
| en1_i | input | 1 | Channel 1 enable (8-bit mode only) |
| per0_i | input | 8 | Channel 0 period shadow / 16-bit period low byte |
| duty0_i | input | 8 | Channel 0 duty shadow / 16-bit duty low byte |
| per1_i | input | 8 | Channel 1 period shadow / 16-bit period high byte |
| duty1_i | input | 8 | Channel 1 duty shadow / 16-bit duty high byte |
| pwm0_o | output | 1 | Channel 0 pin / 16-bit output |
| pwm1_o | output | 1 | Channel 1 pin |

## Verification
Counters and active values update on the rising edge at which a selected tick is present. The pins are decoded from that registered state, so a tick changes the pin at that same edge. An enable change reaches the pin in the same cycle, without waiting for an edge. The bench drives all inputs just after a falling edge and advances its own model of counts and active values for the coming rising edge. It compares both pins at the following falling edge, by which time the registered state and the enable gating have both settled. The dithered mode is also checked by counting high cycles across one complete 65536-count period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SRC_TBASE = 1'b0,
    SRC_TOVF  = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
  import pwm_pkg::*;
(
  input  logic     tb_tick_i,
  input  logic     tmr_ovf_i,
  input  cnt_src_e src_i,
  output logic     tick_o
);
  always_comb begin
    unique case (src_i)
      SRC_TOVF: tick_o = tmr_ovf_i;
      default:  tick_o = tb_tick_i;
    endcase
  end
endmodule

// File: rtl/pwm_byte_cnt.sv
module pwm_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         wrap_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] duty_o
);
  logic load;
  assign load = clr_i | (inc_i & wrap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (inc_i) begin
      cnt_o <= wrap_i ? '0 : cnt_o + 1'b1;
    end
  end

  // shadow to active copy at period boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o  <= '0;
      duty_o <= '0;
    end else if (load) begin
      per_o  <= per_i;
      duty_o <= duty_i;
    end
  end
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic         lvl_o
);
  always_comb begin
    if (duty_i == '0)         lvl_o = 1'b0;
    else if (duty_i >= per_i) lvl_o = 1'b1;
    else                      lvl_o = cnt_i < duty_i;
  end
endmodule

// File: rtl/pwm_dither.sv
module pwm_dither #(
  parameter int W = 8
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] sub_i,
  input  logic [W-1:0] duty_hi_i,
  input  logic [W-1:0] duty_lo_i,
  output logic         lvl_o
);
  logic [W-1:0] sub_rev;
  logic         extra;
  logic [W:0]   thresh;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign sub_rev[i] = sub_i[W-1-i];
  end

  assign extra  = sub_rev < duty_lo_i;
  assign thresh = {1'b0, duty_hi_i} + {{W{1'b0}}, extra};
  assign lvl_o  = {1'b0, pos_i} < thresh;
endmodule

// File: rtl/pwm_dual_wide.sv
module pwm_dual_wide
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tb_tick_i,
  input  logic         tmr_ovf_i,
  input  logic         src_sel_i,
  input  logic         wide_i,
  input  logic         hs_i,
  input  logic         en0_i,
  input  logic         en1_i,
  input  logic [W-1:0] per0_i,
  input  logic [W-1:0] duty0_i,
  input  logic [W-1:0] per1_i,
  input  logic [W-1:0] duty1_i,
  output logic         pwm0_o,
  output logic         pwm1_o
);
  localparam int NCH = 2;
  localparam int WW  = 2 * W;
  localparam logic [W-1:0]  CMAX = '1;
  localparam logic [WW-1:0] WMAX = '1;

  logic tick;
  logic [W-1:0] per_in [NCH];
  logic [W-1:0] duty_in[NCH];
  logic [W-1:0] cnt    [NCH];
  logic [W-1:0] ap     [NCH];
  logic [W-1:0] ad     [NCH];
  logic [NCH-1:0] clr, inc, wrap, lvl;
  logic [NCH-1:0] en;
  logic [WW-1:0] w_cnt, w_per, w_duty;
  logic w_wrap, w_lvl, hs_lvl;

  pwm_tick_sel u_sel (
    .tb_tick_i(tb_tick_i),
    .tmr_ovf_i(tmr_ovf_i),
    .src_i    (cnt_src_e'(src_sel_i)),
    .tick_o   (tick)
  );

  assign per_in[0]  = per0_i;
  assign per_in[1]  = per1_i;
  assign duty_in[0] = duty0_i;
  assign duty_in[1] = duty1_i;
  assign en         = {en1_i, en0_i};

  assign w_cnt  = {cnt[1], cnt[0]};
  assign w_per  = {ap[1], ap[0]};
  assign w_duty = {ad[1], ad[0]};
  assign w_wrap = hs_i ? (w_cnt == WMAX) : (w_cnt == w_per);

  // channel 1 follows channel 0's carry when cascaded
  assign clr[0]  = !en0_i;
  assign inc[0]  = tick;
  assign wrap[0] = wide_i ? w_wrap : (cnt[0] == ap[0]);
  assign clr[1]  = wide_i ? !en0_i : !en1_i;
  assign inc[1]  = wide_i ? tick & ((cnt[0] == CMAX) | w_wrap) : tick;
  assign wrap[1] = wide_i ? w_wrap : (cnt[1] == ap[1]);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm_byte_cnt #(.W(W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr[k]),
      .inc_i (inc[k]),
      .wrap_i(wrap[k]),
      .per_i (per_in[k]),
      .duty_i(duty_in[k]),
      .cnt_o (cnt[k]),
      .per_o (ap[k]),
      .duty_o(ad[k])
    );

    pwm_cmp #(.W(W)) u_cmp (
      .cnt_i (cnt[k]),
      .per_i (ap[k]),
      .duty_i(ad[k]),
      .lvl_o (lvl[k])
    );
  end

  pwm_cmp #(.W(WW)) u_wcmp (
    .cnt_i (w_cnt),
    .per_i (w_per),
    .duty_i(w_duty),
    .lvl_o (w_lvl)
  );

  pwm_dither #(.W(W)) u_dith (
    .pos_i    (cnt[0]),
    .sub_i    (cnt[1]),
    .duty_hi_i(ad[1]),
    .duty_lo_i(ad[0]),
    .lvl_o    (hs_lvl)
  );

  assign pwm0_o = en[0] & (wide_i ? (hs_i ? hs_lvl : w_lvl) : lvl[0]);
  assign pwm1_o = en[1] & !wide_i & lvl[1];

  logic [W-1:0] ap0, ad0, cnt0, cnt1, ap1;
  assign ap0  = ap[0];
  assign ad0  = ad[0];
  assign cnt0 = cnt[0];
  assign cnt1 = cnt[1];
  assign ap1  = ap[1];

  a_r5_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en0_i |=> (cnt0 == '0));

  a_r6_pin1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i |-> !pwm1_o);

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && en1_i) |=> (wide_i || cnt1 <= ap1));

  a_r4_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && ad0 == '0) |-> !pwm0_o);

  a_r3_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && !wide_i && !(tick && cnt0 == ap0)) |=> ($stable(ap0) && $stable(ad0)));
endmodule

// File: tb/pwm_dual_wide_test.sv
module pwm_dual_wide_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tb_tick_i = 0, tmr_ovf_i = 0, src_sel_i = 0, wide_i = 0, hs_i = 0;
  logic en0_i = 0, en1_i = 0;
  logic [7:0] per0_i = 0, duty0_i = 0, per1_i = 0, duty1_i = 0;
  logic pwm0_o, pwm1_o;

  always #(CLK_P/2) clk = ~clk;

  pwm_dual_wide #(.W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tb_tick_i(tb_tick_i), .tmr_ovf_i(tmr_ovf_i),
    .src_sel_i(src_sel_i), .wide_i(wide_i), .hs_i(hs_i), .en0_i(en0_i), .en1_i(en1_i),
    .per0_i(per0_i), .duty0_i(duty0_i), .per1_i(per1_i), .duty1_i(duty1_i),
    .pwm0_o(pwm0_o), .pwm1_o(pwm1_o)
  );

  int checks = 0, fails = 0;
  int m_c[2], m_p[2], m_d[2];
  int tb_pct = 70, ov_pct = 70, chg_pm = 5, en_pm = 0, corner = 0, en1_rand = 0;
  bit done = 0;

  function automatic int rev8(int s);
    int r = 0;
    for (int i = 0; i < 8; i++) if (s[i]) r |= 1 << (7 - i);
    return r;
  endfunction

  function automatic bit lvl(int c, int p, int d);
    if (d == 0) return 0;
    if (d >= p) return 1;
    return c < d;
  endfunction

  function automatic bit hs_lvl(int pos, int sub, int dh, int dl);
    return pos < dh + ((rev8(sub) < dl) ? 1 : 0);
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check_bit(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_pins(string tag);
    bit e0, e1;
    if (wide_i) begin
      e1 = 0;
      if (hs_i) e0 = en0_i && hs_lvl(m_c[0], m_c[1], m_d[1], m_d[0]);
      else      e0 = en0_i && lvl(m_c[1]*256 + m_c[0], m_p[1]*256 + m_p[0], m_d[1]*256 + m_d[0]);
    end else begin
      e0 = en0_i && lvl(m_c[0], m_p[0], m_d[0]);
      e1 = en1_i && lvl(m_c[1], m_p[1], m_d[1]);
    end
    check_bit(tag, pwm0_o, e0, "pwm0");
    check_bit(tag, pwm1_o, e1, "pwm1");
  endtask

  task automatic load(int k);
    m_p[k] = (k == 0) ? int'(per0_i) : int'(per1_i);
    m_d[k] = (k == 0) ? int'(duty0_i) : int'(duty1_i);
  endtask

  task automatic model_update();
    bit t = src_sel_i ? tmr_ovf_i : tb_tick_i;
    if (wide_i) begin
      int cc = m_c[1]*256 + m_c[0];
      int pp = m_p[1]*256 + m_p[0];
      if (!en0_i) begin cc = 0; load(0); load(1); end
      else if (t) begin
        if (hs_i ? (cc == 65535) : (cc == pp)) begin cc = 0; load(0); load(1); end
        else cc++;
      end
      m_c[0] = cc % 256; m_c[1] = cc / 256;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit e = (k == 0) ? en0_i : en1_i;
        if (!e) begin m_c[k] = 0; load(k); end
        else if (t) begin
          if (m_c[k] == m_p[k]) begin m_c[k] = 0; load(k); end
          else m_c[k]++;
        end
      end
    end
  endtask

  task automatic new_values();
    if (wide_i) begin
      per1_i = 8'($urandom % 2); per0_i = 8'($urandom);
      duty1_i = 8'($urandom % 3); duty0_i = 8'($urandom);
    end else begin
      per0_i = 8'($urandom % 40); per1_i = 8'($urandom % 40);
      if (corner != 0) begin
        case ($urandom % 4)
          0: duty0_i = 0;
          1: duty0_i = per0_i;
          2: duty0_i = per0_i + 1;
          default: duty0_i = 8'hFF;
        endcase
        duty1_i = ($urandom % 2 == 0) ? 8'd0 : per1_i;
      end else begin
        duty0_i = 8'($urandom % 48); duty1_i = 8'($urandom % 48);
      end
    end
  endtask

  task automatic step(string tag);
    if (($urandom % 1000) < chg_pm) new_values();
    if (($urandom % 1000) < en_pm) en0_i = ~en0_i;
    if (($urandom % 1000) < en_pm) en1_i = ~en1_i;
    if (en1_rand != 0) en1_i = 1'($urandom % 2);
    tb_tick_i = ($urandom % 100) < tb_pct;
    tmr_ovf_i = ($urandom % 100) < ov_pct;
    model_update();
    @(posedge clk);
    @(negedge clk);
    check_pins(tag);
  endtask

  task automatic quiesce(string tag);
    en0_i = 0; en1_i = 0;
    step(tag);
  endtask

  initial begin
    #(CLK_P * 195000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin m_c[k] = 0; m_p[k] = 0; m_d[k] = 0; end
    per0_i = 8'd9; duty0_i = 8'd4; per1_i = 8'd5; duty1_i = 8'd5;
    en0_i = 1; en1_i = 1;
    repeat (3) @(negedge clk);
    // R8: reset holds pins low despite enables
    check_bit("R8", pwm0_o, 1'b0, "pwm0 in reset");
    check_bit("R8", pwm1_o, 1'b0, "pwm1 in reset");
    en0_i = 0; en1_i = 0;
    @(negedge clk);
    rst_ni = 1;
    step("R8");
    en0_i = 1; en1_i = 1;

    // R1: basic narrow counting, time base
    src_sel_i = 0; tb_pct = 70; ov_pct = 0; chg_pm = 4;
    repeat (4000) step("R1");
    // R2: timer overflow selected, time base noisy
    src_sel_i = 1; tb_pct = 90; ov_pct = 30;
    repeat (3000) step("R2");
    src_sel_i = 0; tb_pct = 0; ov_pct = 100;
    repeat (300) step("R2");
    // R3: frequent shadow changes mid-period
    tb_pct = 80; ov_pct = 80; chg_pm = 150;
    repeat (3000) step("R3");
    // R4: duty corners
    corner = 1; chg_pm = 20;
    repeat (3000) step("R4");
    corner = 0;
    // R5: enable toggling
    en_pm = 15; chg_pm = 5;
    repeat (3000) step("R5");
    en_pm = 0;

    // R6: cascaded 16-bit mode
    quiesce("R6");
    wide_i = 1; hs_i = 0; en1_rand = 1; chg_pm = 3;
    new_values();
    en0_i = 1;
    repeat (9000) step("R6");
    en1_rand = 0;

    // R7: dithered mode over one full period
    quiesce("R7");
    hs_i = 1; src_sel_i = 0; tb_pct = 100; chg_pm = 0;
    per0_i = 8'h03; per1_i = 8'h00; duty1_i = 8'h3A; duty0_i = 8'h97;
    step("R7");
    en0_i = 1;
    hi = 0;
    for (int n = 0; n < 65536; n++) begin
      if (n == 60000) begin duty1_i = 8'hFF; duty0_i = 8'h40; end
      step("R7");
      hi += int'(pwm0_o);
    end
    checks++;
    if (hi != 16'h3A97) begin
      fails++;
      $display("FAIL R7 high count: actual %0d expected %0d", hi, 16'h3A97);
    end
    repeat (8000) step("R7");

    done = 1;
    report();
    $finish;
  end
endmodule